// File: doc/BRIEF.md
# Single-Wire Bus Responder: Reset Detect, Presence Reply and Write-Slot Receiver

This block sits on the responder side of a single-wire, open-drain bus that a pull-up holds high. It watches the line and measures how long each low period lasts. When the master holds the line low for long enough, the block takes that as a bus reset. After the master releases the line, the block waits a fixed delay and then answers with a timed presence pulse, which it makes by pulling the line low through its drive output.

Once it has answered a reset, the block treats each falling edge from the master as the start of a write slot. It samples the line at a fixed point inside the slot and turns the level into a bit. Bits are gathered least significant first. After every eighth bit the block presents the byte together with a one-cycle strobe.

All timing comes from one parameter, the number of clock ticks per microsecond. The top module puts the asynchronous bus input through a synchronizer and releases its own reset synchronously.

Top module: `owr_slave_rx`

## Requirements
- R1: After reset, `drive_low` is 0 and `byte_valid` is 0.
- R2: If the line has been low for at least 480 µs when it rises, the block starts driving `drive_low` high between 15 µs and 60 µs after that rising edge. The nominal delay is 30 µs.
- R3: The presence pulse lasts between 60 µs and 240 µs (nominal 120 µs). After it, `drive_low` returns to 0 and stays there.
- R4: A low period shorter than 480 µs (400 µs in the bench) produces no presence pulse.
- R5: After a falling edge, the line is sampled 30 µs later, which falls inside the 15 to 60 µs window. A high line gives bit 1 and a low line gives bit 0. A 0 bit is committed at the rising edge that ends its slot.
- R6: The first bit received goes to `byte_data[0]` and the eighth goes to `byte_data[7]`. `byte_valid` is high for exactly one cycle after the eighth bit, and `byte_data` is valid in that cycle.
- R7: A reset pulse in the middle of a byte throws away the partial byte and clears the bit count. The next eight bits form a new byte.
- R8: Falling edges seen while the block is waiting to send presence or is driving presence do not start a slot. This includes the edge the block's own presence pulse causes.
- R9: Write slots that come before the first reset pulse are ignored. They produce no `byte_valid`.
- R10: The low period of a reset pulse is never committed as a data bit. Seven bits followed by a reset produce no `byte_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Bus line level, asynchronous |
| drive_low | output | 1 | 1 = pull the bus line low (presence pulse) |
| byte_valid | output | 1 | One-cycle strobe: a received byte is on `byte_data` |
| byte_data | output | DATA_W | Last received byte, LSB received first |

## Verification
The bench builds the block with `TICKS_PER_US = 2` instead of the default of 50. This scales a 480 µs reset down to 960 cycles and a full write slot to about 150 cycles. At that scale, several reset pulses, presence measurements and multi-byte transfers all fit in a short run. The microsecond ratios are unchanged, so the bench still measures the presence delay and length against the 15–60 µs and 60–240 µs windows. It also drives a 400 µs low period as a sub-threshold case and uses 65 µs / 5 µs low times for write slots.

// File: rtl/owr_pkg.sv
package owr_pkg;

  typedef enum logic [1:0] {
    LNK_IDLE   = 2'd0,
    LNK_WAIT   = 2'd1,
    LNK_PRES   = 2'd2,
    LNK_ACTIVE = 2'd3
  } lnk_state_t;

  typedef enum logic [1:0] {
    SMP_IDLE  = 2'd0,
    SMP_TIME  = 2'd1,
    SMP_HOLD0 = 2'd2
  } smp_state_t;

  function automatic int us_to_ticks(input int us, input int ticks_per_us);
    return us * ticks_per_us;
  endfunction

endpackage

// File: rtl/owr_line_sync.sv
module owr_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  output logic line_o,
  output logic fell_o,
  output logic rose_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], bus_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign line_o = sync_q[SYNC_STAGES-1];
  assign fell_o = prev_q & ~line_o;
  assign rose_o = ~prev_q & line_o;

endmodule

// File: rtl/owr_link_ctrl.sv
module owr_link_ctrl
  import owr_pkg::*;
#(
  parameter int RST_TICKS  = 24000,
  parameter int WAIT_TICKS = 1500,
  parameter int PRES_TICKS = 6000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic rose,
  output logic drive_low,
  output logic active,
  output logic rst_det
);

  localparam int LCW = $clog2(RST_TICKS + 1);
  localparam int TMAX = (WAIT_TICKS > PRES_TICKS) ? WAIT_TICKS : PRES_TICKS;
  localparam int TCW = $clog2(TMAX + 1);
  localparam logic [LCW-1:0] LOW_SAT   = LCW'(RST_TICKS);
  localparam logic [TCW-1:0] WAIT_LAST = TCW'(WAIT_TICKS - 1);
  localparam logic [TCW-1:0] PRES_LAST = TCW'(PRES_TICKS - 1);

  lnk_state_t     state_q, state_d;
  logic [LCW-1:0] low_q, low_d;
  logic [TCW-1:0] tmr_q, tmr_d;
  logic           drive_q;
  logic           in_pres;

  assign in_pres = (state_q == LNK_PRES);
  assign rst_det = rose & (low_q == LOW_SAT) & ~in_pres;

  always_comb begin
    low_d = low_q;
    if (line) begin
      low_d = '0;
    end else if (!in_pres && (low_q != LOW_SAT)) begin
      low_d = low_q + 1'b1;
    end
  end

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    unique case (state_q)
      LNK_IDLE, LNK_ACTIVE: begin
        if (rst_det) begin
          state_d = LNK_WAIT;
          tmr_d   = '0;
        end
      end
      LNK_WAIT: begin
        if (rst_det) begin
          tmr_d = '0;
        end else if (tmr_q == WAIT_LAST) begin
          state_d = LNK_PRES;
          tmr_d   = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      LNK_PRES: begin
        if (tmr_q == PRES_LAST) begin
          state_d = LNK_ACTIVE;
          tmr_d   = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: begin
        state_d = LNK_IDLE;
        tmr_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LNK_IDLE;
      tmr_q   <= '0;
      low_q   <= '0;
      drive_q <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      low_q   <= low_d;
      drive_q <= (state_d == LNK_PRES);
    end
  end

  assign drive_low = drive_q;
  assign active    = (state_q == LNK_ACTIVE);

endmodule

// File: rtl/owr_slot_sampler.sv
module owr_slot_sampler
  import owr_pkg::*;
#(
  parameter int SAMPLE_TICKS = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic line,
  input  logic fell,
  input  logic rose,
  input  logic rst_det,
  output logic bit_stb,
  output logic bit_val
);

  localparam int SCW = $clog2(SAMPLE_TICKS + 1);
  localparam logic [SCW-1:0] SMP_LAST = SCW'(SAMPLE_TICKS - 1);

  smp_state_t     state_q, state_d;
  logic [SCW-1:0] cnt_q, cnt_d;
  logic           stb_q, stb_d;
  logic           val_q, val_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    stb_d   = 1'b0;
    val_d   = val_q;
    unique case (state_q)
      SMP_IDLE: begin
        if (en && fell) begin
          state_d = SMP_TIME;
          cnt_d   = '0;
        end
      end
      SMP_TIME: begin
        if (!en) begin
          state_d = SMP_IDLE;
        end else if (cnt_q == SMP_LAST) begin
          if (line) begin
            stb_d   = 1'b1;
            val_d   = 1'b1;
            state_d = SMP_IDLE;
          end else begin
            state_d = SMP_HOLD0;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SMP_HOLD0: begin
        if (!en) begin
          state_d = SMP_IDLE;
        end else if (rose) begin
          state_d = SMP_IDLE;
          if (!rst_det) begin
            stb_d = 1'b1;
            val_d = 1'b0;
          end
        end
      end
      default: state_d = SMP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SMP_IDLE;
      cnt_q   <= '0;
      stb_q   <= 1'b0;
      val_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      stb_q   <= stb_d;
      val_q   <= val_d;
    end
  end

  assign bit_stb = stb_q;
  assign bit_val = val_q;

endmodule

// File: rtl/owr_byte_shifter.sv
module owr_byte_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              bit_stb,
  input  logic              bit_val,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_data,
  output logic [$clog2(DATA_W)-1:0] bit_cnt
);

  localparam int BCW = $clog2(DATA_W);
  localparam logic [BCW-1:0] CNT_LAST = BCW'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, sh_d, sh_new;
  logic [DATA_W-1:0] out_q, out_d;
  logic [BCW-1:0]    cnt_q, cnt_d;
  logic              vld_q, vld_d;

  assign sh_new = {bit_val, sh_q[DATA_W-1:1]};

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    out_d = out_q;
    vld_d = 1'b0;
    if (clear) begin
      cnt_d = '0;
    end else if (bit_stb) begin
      sh_d = sh_new;
      if (cnt_q == CNT_LAST) begin
        cnt_d = '0;
        out_d = sh_new;
        vld_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      out_q <= out_d;
      vld_q <= vld_d;
    end
  end

  assign byte_valid = vld_q;
  assign byte_data  = out_q;
  assign bit_cnt    = cnt_q;

endmodule

// File: rtl/owr_slave_rx.sv
module owr_slave_rx
  import owr_pkg::*;
#(
  parameter int TICKS_PER_US  = 50,
  parameter int RESET_US      = 480,
  parameter int PRES_DELAY_US = 30,
  parameter int PRES_LEN_US   = 120,
  parameter int SAMPLE_US     = 30,
  parameter int DATA_W        = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_in,
  output logic              drive_low,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_data
);

  localparam int RST_TICKS    = us_to_ticks(RESET_US, TICKS_PER_US);
  localparam int WAIT_TICKS   = us_to_ticks(PRES_DELAY_US, TICKS_PER_US);
  localparam int PRES_TICKS   = us_to_ticks(PRES_LEN_US, TICKS_PER_US);
  localparam int SAMPLE_TICKS = us_to_ticks(SAMPLE_US, TICKS_PER_US);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  logic line, fell, rose;
  logic link_active, rst_det;
  logic bit_stb, bit_val;
  logic [$clog2(DATA_W)-1:0] bit_cnt;

  owr_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .bus_in (bus_in),
    .line_o (line),
    .fell_o (fell),
    .rose_o (rose)
  );

  owr_link_ctrl #(
    .RST_TICKS  (RST_TICKS),
    .WAIT_TICKS (WAIT_TICKS),
    .PRES_TICKS (PRES_TICKS)
  ) link_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .line      (line),
    .rose      (rose),
    .drive_low (drive_low),
    .active    (link_active),
    .rst_det   (rst_det)
  );

  owr_slot_sampler #(.SAMPLE_TICKS(SAMPLE_TICKS)) smp_i (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .en      (link_active),
    .line    (line),
    .fell    (fell),
    .rose    (rose),
    .rst_det (rst_det),
    .bit_stb (bit_stb),
    .bit_val (bit_val)
  );

  owr_byte_shifter #(.DATA_W(DATA_W)) shf_i (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .clear      (rst_det),
    .bit_stb    (bit_stb),
    .bit_val    (bit_val),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .bit_cnt    (bit_cnt)
  );

endmodule

// File: rtl/owr_slave_rx_chk.sv
module owr_slave_rx_chk #(
  parameter int PRES_TICKS = 6000,
  parameter int DATA_W     = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      drive_low,
  input logic                      byte_valid,
  input logic                      bit_stb,
  input logic                      link_active,
  input logic                      rst_det,
  input logic [$clog2(DATA_W)-1:0] bit_cnt
);

  localparam int RCW = $clog2(PRES_TICKS + 2);
  localparam logic [$clog2(DATA_W)-1:0] CNT_LAST = ($clog2(DATA_W))'(DATA_W - 1);

  logic [RCW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (drive_low) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  AST_PRES_NOT_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_det |=> !drive_low); // R2

  AST_PRES_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_low) |-> (run_q == RCW'(PRES_TICKS))); // R3

  AST_PRES_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |-> (run_q < RCW'(PRES_TICKS))); // R3

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid); // R6

  AST_STROBE_AFTER_EIGHTH: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> ($past(bit_stb) && ($past(bit_cnt) == CNT_LAST))); // R6

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_det |=> (bit_cnt == '0)); // R7

  AST_BITS_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> $past(link_active)); // R8

endmodule

bind owr_slave_rx owr_slave_rx_chk #(
  .PRES_TICKS (PRES_TICKS),
  .DATA_W     (DATA_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .drive_low   (drive_low),
  .byte_valid  (byte_valid),
  .bit_stb     (bit_stb),
  .link_active (link_active),
  .rst_det     (rst_det),
  .bit_cnt     (bit_cnt)
);

// File: tb/owr_slave_rx_tb_top.sv
`timescale 1ns/1ps
module owr_slave_rx_tb_top;

  localparam int TPU = 2;

  logic       clk;
  logic       rst_n;
  logic       master_low;
  logic       bus_in;
  logic       drive_low;
  logic       byte_valid;
  logic [7:0] byte_data;

  int n_checks;
  int n_fail;
  int cyc;
  int t_rel, t_rise, t_fall;
  int pres_rises;
  int byte_count;
  logic [7:0] last_byte;
  logic dl_prev;

  assign bus_in = ~(master_low | drive_low);

  owr_slave_rx #(.TICKS_PER_US(TPU)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_in     (bus_in),
    .drive_low  (drive_low),
    .byte_valid (byte_valid),
    .byte_data  (byte_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    dl_prev <= drive_low;
    if (rst_n && drive_low && !dl_prev) begin
      t_rise <= cyc;
      pres_rises <= pres_rises + 1;
    end
    if (rst_n && !drive_low && dl_prev) t_fall <= cyc;
    if (rst_n && byte_valid) begin
      byte_count <= byte_count + 1;
      last_byte  <= byte_data;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_us(input int us);
    repeat (us * TPU) @(negedge clk);
  endtask

  task automatic bus_reset(input int low_us);
    @(negedge clk);
    master_low = 1'b1;
    wait_us(low_us);
    master_low = 1'b0;
    t_rel = cyc;
    wait_us(260);
  endtask

  task automatic write_bit(input bit b);
    @(negedge clk);
    master_low = 1'b1;
    wait_us(b ? 5 : 65);
    master_low = 1'b0;
    wait_us(b ? 65 : 5);
    wait_us(5);
  endtask

  task automatic write_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) write_bit(v[i]);
    wait_us(2);
  endtask

  task automatic t_reset_state();
    check(drive_low == 1'b0, "R1 drive_low after reset", drive_low, 0);
    check(byte_valid == 1'b0, "R1 byte_valid after reset", byte_valid, 0);
  endtask

  task automatic t_before_first_reset();
    int b0;
    b0 = byte_count;
    write_byte(8'h5A);
    write_byte(8'hFF);
    check(byte_count == b0, "R9 bytes before first reset", byte_count, b0);
    check(pres_rises == 0, "R9 no presence before reset", pres_rises, 0);
  endtask

  task automatic t_presence();
    int p0, dly, len;
    p0 = pres_rises;
    bus_reset(500);
    dly = (t_rise - t_rel) / TPU;
    len = (t_fall - t_rise) / TPU;
    check(pres_rises == p0 + 1, "R2 one presence pulse", pres_rises, p0 + 1);
    check(dly >= 15 && dly <= 60, "R2 presence delay us", dly, 30);
    check(len >= 60 && len <= 240, "R3 presence length us", len, 120);
    check(drive_low == 1'b0, "R3 released after presence", drive_low, 0);
  endtask

  task automatic t_byte(input logic [7:0] v, input string req);
    int b0;
    b0 = byte_count;
    write_byte(v);
    check(byte_count == b0 + 1, req, byte_count, b0 + 1);
    check(last_byte == v, req, last_byte, v);
  endtask

  task automatic t_short_low();
    int p0;
    p0 = pres_rises;
    bus_reset(400);
    check(pres_rises == p0, "R4 short low gives no presence", pres_rises, p0);
    check(drive_low == 1'b0, "R4 drive stays released", drive_low, 0);
  endtask

  task automatic t_mid_byte_reset();
    int b0;
    for (int i = 0; i < 5; i++) write_bit(1'b1);
    t_presence();
    t_byte(8'h96, "R7 byte after mid-byte reset");
    b0 = byte_count;
    for (int i = 0; i < 7; i++) write_bit(1'b0);
    bus_reset(500);
    check(byte_count == b0, "R10 reset low not committed as eighth bit", byte_count, b0);
    t_byte(8'h81, "R10 byte after seven-bit abort");
  endtask

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        while (wd < 190000) begin
          @(posedge clk);
          wd++;
        end
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    join_none
  end

  initial begin
    n_checks = 0; n_fail = 0; cyc = 0;
    t_rel = 0; t_rise = 0; t_fall = 0;
    pres_rises = 0; byte_count = 0; last_byte = '0; dl_prev = 1'b0;
    master_low = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    t_reset_state();
    t_before_first_reset();
    t_presence();
    t_byte(8'hA5, "R5 R6 R8 byte A5 LSB first");
    t_byte(8'h00, "R5 all-zero byte");
    t_byte(8'hFF, "R5 all-one byte");
    t_byte(8'h3C, "R6 byte 3C");
    t_short_low();
    t_presence();
    t_byte(8'hC3, "R8 byte after second presence");
    t_mid_byte_reset();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule